// File: doc/BRIEF.md
# Frame-Locked Sync Pulse Line Transmitter

This block drives one serial line that many receivers share. Time on the line is cut into frames of a fixed number of clocks, set by a free-running frame counter. Early in every frame the line goes high for a short sync pulse. Receivers lock their own frame timing to the leading edge of that pulse. After a short low guard gap, a fixed number of data bits follow at fixed clock offsets. Each bit is held for a set number of clocks, and the most significant bit goes first. No start or stop bits are used. The bit positions come only from their distance to the sync edge.

A word is offered through a valid/ready pair. The block raises ready for one clock only, in the last clock of each frame. A word that is valid in that clock goes out in the next frame. A word offered at any other time waits. When no word is offered at the boundary, the next frame is a null frame: the sync pulse is still sent and every data bit is zero, so receivers never lose lock. A strobe marks the first clock of each frame.

The line sequencer is a state machine with five states. LEAD is the low stretch before the sync pulse. SYNC is the pulse. GUARD is the low gap. DATA is the bit window. TAIL is the low stretch after the last bit. The transitions are: LEAD to SYNC when the count reaches the sync offset; SYNC to GUARD when the pulse width has elapsed; GUARD to DATA at the first bit position; DATA to TAIL after the last bit. From any state, the sequencer goes to LEAD on the frame wrap, and the wrap takes priority over every other transition. The parameters are checked at elaboration. The last data bit must end no later than the last clock of the frame, the sync offset and the guard gap must each be at least one clock, and a word must have at least two bits.

Top module: `sp_sync_tx`

## Requirements
- R1: The frame counter repeats every FRAME_LEN clocks. frame_start is high for exactly one clock, when the count is 0 (the first clock of a frame).
- R2: In every frame, line_o is high during frame clocks SYNC_OFS through SYNC_OFS+SYNC_W-1, and in no other clock of that window.
- R3: line_o is low before the sync pulse, during the GUARD clocks after it, and after the last data bit until the frame ends.
- R4: Data bit i (i = 0 is word bit NBITS-1, the MSB) occupies frame clocks DATA_START+i*BIT_W through DATA_START+(i+1)*BIT_W-1, where DATA_START = SYNC_OFS+SYNC_W+GUARD. A high bit drives line_o high and a low bit drives it low.
- R5: in_ready is high only in frame clock FRAME_LEN-1. When in_valid is also high in that clock, the word is taken on that edge and is sent in the following frame.
- R6: A frame whose boundary saw no valid word carries all-zero data bits and still carries its sync pulse.
- R7: A word offered in the middle of a frame is not taken. The frame in progress is unchanged, and the word stays pending until the next boundary.
- R8: While synchronous reset is high, line_o, in_ready and frame_start are all low. The first frame after reset is a null frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A data word is offered |
| in_ready | output | 1 | High in the last clock of a frame; the word is taken on that edge |
| in_data | input | NBITS | Word to send, MSB first |
| line_o | output | 1 | Serial line: sync pulse followed by data bits |
| frame_start | output | 1 | High in the first clock of every frame |

## Verification
With the default parameters, the bit window ends in the last clock of the frame. The final bit shift and the reload of the next word therefore fall on the same edge, the edge that also wraps the counter and accepts the handshake. Back-to-back words with different MSB and LSB values (A5, FF, 01, 80) provoke this case. The bench judges it by comparing every line sample of each frame against a scoreboard entry pushed at the boundary. The last bit of one word must stay whole, and the next frame must start with a clean sync pulse and the new word's MSB. A word raised mid-frame is also checked: ready must stay low, and the frame in flight must still match its queued value.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [2:0] {
        S_LEAD  = 3'd0,
        S_SYNC  = 3'd1,
        S_GUARD = 3'd2,
        S_DATA  = 3'd3,
        S_TAIL  = 3'd4
    } line_state_e;

endpackage

// File: rtl/sp_frame_ctr.sv
module sp_frame_ctr #(
    parameter int FRAME_LEN = 50,
    parameter int CW        = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign wrap = (cnt == LAST);

    // R1: the count restarts right after the last clock of a frame
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST) |=> (cnt == '0));

endmodule

// File: rtl/sp_word_shift.sv
module sp_word_shift #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             take,
    input  logic [NBITS-1:0] din,
    input  logic             shift,
    output logic             msb
);

    logic [NBITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (load)
            sh <= take ? din : '0;
        else if (shift)
            sh <= {sh[NBITS-2:0], 1'b0};
    end

    assign msb = sh[NBITS-1];

endmodule

// File: rtl/sp_line_fsm.sv
module sp_line_fsm
    import sp_pkg::*;
#(
    parameter int FRAME_LEN = 50,
    parameter int SYNC_OFS  = 2,
    parameter int SYNC_W    = 6,
    parameter int GUARD     = 2,
    parameter int BIT_W     = 5,
    parameter int NBITS     = 8,
    parameter int CW        = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic          wrap,
    input  logic          msb,
    output logic          shift_en,
    output logic          line
);

    localparam int SYNC_END   = SYNC_OFS + SYNC_W;
    localparam int DATA_START = SYNC_END + GUARD;
    localparam int DATA_END   = DATA_START + NBITS * BIT_W;
    localparam int TW         = $clog2(BIT_W + 1);

    line_state_e     state, nxt;
    logic [TW-1:0]   tmr;

    always_ff @(posedge clk) begin
        if (rst)
            state <= S_LEAD;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (wrap) begin
            nxt = S_LEAD;
        end else begin
            unique case (state)
                S_LEAD:  if (cnt == CW'(SYNC_OFS - 1))   nxt = S_SYNC;
                S_SYNC:  if (cnt == CW'(SYNC_END - 1))   nxt = S_GUARD;
                S_GUARD: if (cnt == CW'(DATA_START - 1)) nxt = S_DATA;
                S_DATA:  if (cnt == CW'(DATA_END - 1))   nxt = S_TAIL;
                S_TAIL:  nxt = S_TAIL;
                default: nxt = S_LEAD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state != S_DATA)
            tmr <= '0;
        else if (tmr == TW'(BIT_W - 1))
            tmr <= '0;
        else
            tmr <= tmr + 1'b1;
    end

    always_comb begin
        line     = 1'b0;
        shift_en = 1'b0;
        unique case (state)
            S_SYNC: line = 1'b1;
            S_DATA: begin
                line     = msb;
                shift_en = (tmr == TW'(BIT_W - 1));
            end
            default: begin
                line     = 1'b0;
                shift_en = 1'b0;
            end
        endcase
    end

    // R2: the pulse state lines up with the counter's sync window
    a_r2_sync_window: assert property (@(posedge clk) disable iff (rst)
        (state == S_SYNC) |-> (int'(cnt) >= SYNC_OFS && int'(cnt) < SYNC_END));

    // R4: the bit window sits at its fixed offset behind the sync edge
    a_r4_data_window: assert property (@(posedge clk) disable iff (rst)
        (state == S_DATA) |-> (int'(cnt) >= DATA_START && int'(cnt) < DATA_END));

endmodule

// File: rtl/sp_sync_tx.sv
module sp_sync_tx #(
    parameter int FRAME_LEN = 50,
    parameter int SYNC_OFS  = 2,
    parameter int SYNC_W    = 6,
    parameter int GUARD     = 2,
    parameter int BIT_W     = 5,
    parameter int NBITS     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [NBITS-1:0] in_data,
    output logic             line_o,
    output logic             frame_start
);

    localparam int CW       = $clog2(FRAME_LEN);
    localparam int DATA_END = SYNC_OFS + SYNC_W + GUARD + NBITS * BIT_W;

    generate
        if (DATA_END > FRAME_LEN || SYNC_OFS < 1 || GUARD < 1 ||
            SYNC_W < 1 || BIT_W < 1 || NBITS < 2) begin : g_bad_params
            $error("sp_sync_tx: data bits overrun the frame or a field is too small");
        end
    endgenerate

    logic [CW-1:0] cnt;
    logic          wrap;
    logic          msb;
    logic          shift_en;

    sp_frame_ctr #(
        .FRAME_LEN(FRAME_LEN),
        .CW       (CW)
    ) u_ctr (
        .clk (clk),
        .rst (rst),
        .cnt (cnt),
        .wrap(wrap)
    );

    sp_word_shift #(
        .NBITS(NBITS)
    ) u_shift (
        .clk  (clk),
        .rst  (rst),
        .load (wrap),
        .take (in_valid),
        .din  (in_data),
        .shift(shift_en),
        .msb  (msb)
    );

    sp_line_fsm #(
        .FRAME_LEN(FRAME_LEN),
        .SYNC_OFS (SYNC_OFS),
        .SYNC_W   (SYNC_W),
        .GUARD    (GUARD),
        .BIT_W    (BIT_W),
        .NBITS    (NBITS),
        .CW       (CW)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .wrap    (wrap),
        .msb     (msb),
        .shift_en(shift_en),
        .line    (line_o)
    );

    assign in_ready    = wrap & ~rst;
    assign frame_start = (cnt == '0) & ~rst;

    // R5: a ready clock is always followed by the first clock of a frame
    a_r5_ready_then_start: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> frame_start);

    // R3: the line stays low ahead of the sync pulse
    a_r3_lead_low: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) < SYNC_OFS) |-> !line_o);

    // R1: the start strobe never lasts two clocks
    a_r1_single_start: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

endmodule

// File: tb/sim_sp_sync_tx.sv
module sim_sp_sync_tx;

    localparam int CLK_P = 10;
    localparam int FL    = 50;
    localparam int SO    = 2;
    localparam int SW    = 6;
    localparam int GD    = 2;
    localparam int BW    = 5;
    localparam int NB    = 8;
    localparam int DS    = SO + SW + GD;
    localparam int DE    = DS + NB * BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [NB-1:0] in_data = '0;
    logic          in_ready;
    logic          line_o;
    logic          frame_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [NB-1:0] q_word[$];
    bit            q_null[$];

    int            k = 0;
    bit            active = 1'b0;
    int            frame_no = -1;
    int            frames_done = 0;
    logic [NB-1:0] cur;
    bit            cur_null;
    int            bad_sync, bad_data, bad_quiet, bad_rdy;

    always #(CLK_P/2) clk = ~clk;

    sp_sync_tx #(
        .FRAME_LEN(FL), .SYNC_OFS(SO), .SYNC_W(SW),
        .GUARD(GD), .BIT_W(BW), .NBITS(NB)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .line_o     (line_o),
        .frame_start(frame_start)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_line(input int kk, input logic [NB-1:0] w);
        if (kk >= SO && kk < SO + SW) return 1'b1;
        if (kk >= DS && kk < DE) return w[NB-1-(kk-DS)/BW];
        return 1'b0;
    endfunction

    // Driver side: record what the design should send in the next frame
    always @(negedge clk) begin
        if (!rst && in_ready) begin
            q_word.push_back(in_valid ? in_data : '0);
            q_null.push_back(!in_valid);
        end
    end

    // Monitor: pop one expected word per frame and compare every line sample
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (frame_start) begin
                if (active) chk(k == FL, "R1", "frame length", k, FL);
                if (q_word.size() == 0) begin
                    chk(1'b0, "R5", "no expected word queued", 0, 1);
                    cur = '0; cur_null = 1'b1;
                end else begin
                    cur = q_word.pop_front();
                    cur_null = q_null.pop_front();
                end
                active = 1'b1; k = 0; frame_no++;
                bad_sync = 0; bad_data = 0; bad_quiet = 0; bad_rdy = 0;
            end
            if (active) begin
                if (k >= FL) begin
                    chk(1'b0, "R1", "missing frame_start, clocks since", k, FL);
                    active = 1'b0;
                end else begin
                    if (line_o !== exp_line(k, cur)) begin
                        if (k >= SO && k < SO + SW) bad_sync++;
                        else if (k >= DS && k < DE) bad_data++;
                        else bad_quiet++;
                    end
                    if (in_ready !== (k == FL - 1)) bad_rdy++;
                    if (k == FL - 1) begin
                        chk(bad_sync == 0, "R2", "sync pulse samples wrong", bad_sync, 0);
                        chk(bad_quiet == 0, "R3", "low stretch samples wrong", bad_quiet, 0);
                        chk(bad_rdy == 0, "R5", "ready outside last clock", bad_rdy, 0);
                        if (frame_no == 0)
                            chk(bad_data == 0, "R8", "first frame not null", bad_data, 0);
                        else if (cur_null)
                            chk(bad_data == 0, "R6", "null frame bits", bad_data, 0);
                        else
                            chk(bad_data == 0, "R4", "data bits wrong", bad_data, 0);
                        frames_done++;
                    end
                    k++;
                end
            end
        end
    end

    task automatic send(input logic [NB-1:0] w);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_data  = '0;
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = frames_done + n;
        while (frames_done < target) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(line_o == 1'b0, "R8", "line during reset", int'(line_o), 0);
        chk(in_ready == 1'b0, "R8", "ready during reset", int'(in_ready), 0);
        chk(frame_start == 1'b0, "R8", "frame_start during reset", int'(frame_start), 0);
        @(posedge clk); #1;
        q_word.push_back('0);
        q_null.push_back(1'b1);
        rst = 1'b0;

        // back-to-back words: last bit and reload share the wrap edge (R4)
        send(8'hA5);
        send(8'hFF);
        send(8'h01);
        send(8'h80);
        // idle frames become null frames (R6)
        wait_frames(3);
        wait_frames(2);
        // R7: offer a word mid-frame; it must wait for the boundary
        while (!(active && k == 20)) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = 8'h3C;
        @(negedge clk);
        chk(in_ready == 1'b0, "R7", "ready mid-frame", int'(in_ready), 0);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_data  = '0;
        send(8'h7E);
        wait_frames(3);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            finish_run();
        end
    end

endmodule